// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the status side of a flash device's host bus. It watches write strobes to pick out the unlock-and-command sequences that start a program, a chip erase or a sector erase. While the internal operation runs, every host read returns a status byte instead of array data. The status byte carries a data-polling bit, a toggle bit that flips on each read, a timing-limit bit, a sector-erase timer bit and a suspend toggle bit. When the operation finishes, reads return array contents again.

The cell array is not part of the block. An operation that reaches a real sector ends when `op_done` pulses, and `limit_hit` reports that the internal pulse count ran out. A protected target gives a timed fake operation: the status toggles for a set number of cycles and the data is left unchanged. Every interval is a parameter in clock cycles.

Command decoder states: C_IDLE, C_U1 (first unlock seen), C_U2 (second unlock seen), C_PG (awaiting program address and data), C_E3 (erase setup seen), C_E4, C_E5 (erase unlocks seen). Controller states: S_READ, S_PROG, S_PROT_PROG, S_SE_WIN, S_ERASE, S_PROT_ERASE, S_SUSP, S_FAIL. Controller transitions:
- READ to PROG or PROT_PROG on a program command.
- READ to ERASE or PROT_ERASE on a chip erase.
- READ to SE_WIN on a sector erase.
- PROG or ERASE to READ on `op_done`.
- PROG or ERASE to FAIL on `limit_hit`.
- PROT_PROG and PROT_ERASE to READ when their timer ends.
- SE_WIN to ERASE or PROT_ERASE when the window closes.
- ERASE to SUSP on a suspend write.
- SUSP to ERASE on a resume write.
- FAIL to READ on a reset write.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is in read mode, and `dout` equals `array_data`, including during host reads.
- R2: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0 followed by any address with data D start a program on the rising edge of the fourth write strobe. The first read after it returns bit7 = NOT D[7], bit6 = 1, and 0 in bits 5..0. Unlock addresses compare address bits 10..0 only.
- R3: While an operation is busy and not suspended, each read start (chip enable and output enable both low with write enable high, beginning this cycle) inverts status bit6. Bit6 is cleared when an operation starts from read mode.
- R4: A pulse on `op_done` during a program or an erase returns the block to read mode.
- R5: A program whose `sect_prot` is high at the fourth strobe toggles status for PROT_PROG_CYC cycles while ignoring `op_done`, then returns to read mode.
- R6: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10 start a chip erase on the sixth strobe. Its status shows bit7 = 0 and bit3 = 1.
- R7: The same five writes followed by data 0x30 at a sector address open a sector-erase window of SE_WIN_CYC cycles, during which bit3 reads 0. A further 0x30 write restarts the window and adds that sector. After the window closes, bit3 reads 1.
- R8: A chip erase with `all_prot` high, or a window whose added sectors were all protected, toggles for PROT_ERASE_CYC cycles while ignoring `op_done`, then returns to read mode.
- R9: A 0xB0 write during an erase suspends it. While suspended, bit6 holds, bit2 flips on each read, and bit7 and bit3 read 1. A 0x30 write resumes the erase.
- R10: Status bit2 flips on each read start during erase-related states and stays 0 during a program.
- R11: `limit_hit` during a program or an erase sets bit5. Bit6 keeps flipping and `op_done` is ignored until a 0xF0 write returns the block to read mode.
- R12: A 0xF0 write, or any write that does not match the next step, sends the command sequence back to idle. A 0xF0 write during a busy operation other than a timing-limit failure has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Host address |
| din | input | 8 | Host write data |
| array_data | input | 8 | Array contents at the current address |
| sect_prot | input | 1 | The addressed sector is protected |
| all_prot | input | 1 | Every sector is protected |
| op_done | input | 1 | Internal operation finished (pulse) |
| limit_hit | input | 1 | Internal pulse count exceeded (pulse) |
| dout | output | 8 | Read data: status byte while busy, else array data |

## Verification
A write event happens on the first clock edge at which `we_n` is sampled high after being low while `ce_n` is low. The controller state changes on that same edge, so the bench reads status no earlier than the following half cycle. A read start flips the toggle bits on the first edge at which both enables are seen low, and `dout` is combinational from those registers. Each read therefore samples on the falling edge after that first rising edge, and the expected toggle values are tracked as a count of read starts since the operation began. Timed intervals are checked on both sides of their end, with margins of several cycles from the parameter values.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [2:0] {
        S_READ,
        S_PROG,
        S_PROT_PROG,
        S_SE_WIN,
        S_ERASE,
        S_PROT_ERASE,
        S_SUSP,
        S_FAIL
    } op_state_t;

    typedef enum logic [2:0] {
        C_IDLE,
        C_U1,
        C_U2,
        C_PG,
        C_E3,
        C_E4,
        C_E5
    } cmd_state_t;

    localparam int UNL_W = 11;
    localparam logic [UNL_W-1:0] ADR_A = 11'h555;
    localparam logic [UNL_W-1:0] ADR_B = 11'h2AA;

    localparam logic [7:0] K_UNL1   = 8'hAA;
    localparam logic [7:0] K_UNL2   = 8'h55;
    localparam logic [7:0] K_PROG   = 8'hA0;
    localparam logic [7:0] K_ESETUP = 8'h80;
    localparam logic [7:0] K_CHIP   = 8'h10;
    localparam logic [7:0] K_SECT   = 8'h30;
    localparam logic [7:0] K_SUSP   = 8'hB0;
    localparam logic [7:0] K_RESET  = 8'hF0;

    localparam int BIT_POLL = 7;
    localparam int BIT_TGL  = 6;
    localparam int BIT_LIM  = 5;
    localparam int BIT_SET  = 3;
    localparam int BIT_STGL = 2;

endpackage

// File: rtl/fsg_bus_sense.sv
module fsg_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_strobe,
    output logic rd_start
);
    logic we_q;
    logic rd_q;
    logic rd_act;

    assign rd_act = !ce_n && !oe_n && we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            rd_q <= 1'b0;
        end else begin
            we_q <= we_n;
            rd_q <= rd_act;
        end
    end

    assign wr_strobe = we_n && !we_q && !ce_n;
    assign rd_start  = rd_act && !rd_q;

endmodule

// File: rtl/fsg_cmd_decode.sv
module fsg_cmd_decode
    import flash_stat_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              ev_prog,
    output logic              ev_chip,
    output logic              ev_sect,
    output logic              ev_more,
    output logic              ev_susp,
    output logic              ev_reset
);
    cmd_state_t cs, cs_nxt;
    logic at_a, at_b;
    logic unused_hi;

    assign at_a = addr[UNL_W-1:0] == ADR_A;
    assign at_b = addr[UNL_W-1:0] == ADR_B;
    assign unused_hi = ^addr[ADDR_W-1:UNL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs <= C_IDLE;
        else        cs <= cs_nxt;
    end

    always_comb begin
        cs_nxt   = cs;
        ev_prog  = 1'b0;
        ev_chip  = 1'b0;
        ev_sect  = 1'b0;
        ev_more  = 1'b0;
        ev_susp  = 1'b0;
        ev_reset = 1'b0;
        if (wr_strobe) begin
            if (cs != C_PG && din == K_RESET) begin
                ev_reset = 1'b1;
                cs_nxt   = C_IDLE;
            end else begin
                unique case (cs)
                    C_IDLE: begin
                        if (at_a && din == K_UNL1) cs_nxt = C_U1;
                        else if (din == K_SUSP)    ev_susp = 1'b1;
                        else if (din == K_SECT)    ev_more = 1'b1;
                    end
                    C_U1: cs_nxt = (at_b && din == K_UNL2) ? C_U2 : C_IDLE;
                    C_U2: begin
                        if (at_a && din == K_PROG)        cs_nxt = C_PG;
                        else if (at_a && din == K_ESETUP) cs_nxt = C_E3;
                        else                              cs_nxt = C_IDLE;
                    end
                    C_PG: begin
                        ev_prog = 1'b1;
                        cs_nxt  = C_IDLE;
                    end
                    C_E3: cs_nxt = (at_a && din == K_UNL1) ? C_E4 : C_IDLE;
                    C_E4: cs_nxt = (at_b && din == K_UNL2) ? C_E5 : C_IDLE;
                    C_E5: begin
                        if (at_a && din == K_CHIP) ev_chip = 1'b1;
                        else if (din == K_SECT)    ev_sect = 1'b1;
                        cs_nxt = C_IDLE;
                    end
                    default: cs_nxt = C_IDLE;
                endcase
            end
        end
    end

    assert_one_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_prog, ev_chip, ev_sect, ev_more, ev_susp, ev_reset}));

    assert_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && cs != C_PG && din == K_RESET) |=> cs == C_IDLE);

endmodule

// File: rtl/fsg_op_ctrl.sv
module fsg_op_ctrl
    import flash_stat_pkg::*;
#(
    parameter int PROT_PROG_CYC  = 125_000_000,
    parameter int PROT_ERASE_CYC = 50_000,
    parameter int SE_WIN_CYC     = 6_250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_prog,
    input  logic       ev_chip,
    input  logic       ev_sect,
    input  logic       ev_more,
    input  logic       ev_susp,
    input  logic       ev_reset,
    input  logic       rd_start,
    input  logic       prog_d7,
    input  logic       sect_prot,
    input  logic       all_prot,
    input  logic       op_done,
    input  logic       limit_hit,
    output logic [7:0] stat,
    output logic       show_stat
);
    localparam int MAX_AB  = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
    localparam int MAX_CYC = (MAX_AB > SE_WIN_CYC) ? MAX_AB : SE_WIN_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    op_state_t st, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;
    logic timed;
    logic timer_hit;
    logic tog6, tog2, poll, is_erase, any_unprot;

    always_comb begin
        timed  = 1'b1;
        lim_m1 = '0;
        unique case (st)
            S_PROT_PROG:  lim_m1 = CNT_W'(PROT_PROG_CYC - 1);
            S_PROT_ERASE: lim_m1 = CNT_W'(PROT_ERASE_CYC - 1);
            S_SE_WIN:     lim_m1 = CNT_W'(SE_WIN_CYC - 1);
            default:      timed  = 1'b0;
        endcase
    end
    assign timer_hit = timed && (cnt == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_READ;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_READ: begin
                if (ev_prog)      nxt = sect_prot ? S_PROT_PROG : S_PROG;
                else if (ev_chip) nxt = all_prot ? S_PROT_ERASE : S_ERASE;
                else if (ev_sect) nxt = S_SE_WIN;
            end
            S_PROG: begin
                if (limit_hit)    nxt = S_FAIL;
                else if (op_done) nxt = S_READ;
            end
            S_PROT_PROG:  if (timer_hit) nxt = S_READ;
            S_SE_WIN:     if (timer_hit && !ev_more) nxt = any_unprot ? S_ERASE : S_PROT_ERASE;
            S_ERASE: begin
                if (limit_hit)    nxt = S_FAIL;
                else if (ev_susp) nxt = S_SUSP;
                else if (op_done) nxt = S_READ;
            end
            S_PROT_ERASE: if (timer_hit) nxt = S_READ;
            S_SUSP:       if (ev_more)   nxt = S_ERASE;
            S_FAIL:       if (ev_reset)  nxt = S_READ;
            default:      nxt = S_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            tog6       <= 1'b0;
            tog2       <= 1'b0;
            poll       <= 1'b0;
            is_erase   <= 1'b0;
            any_unprot <= 1'b0;
        end else begin
            if (nxt != st || (st == S_SE_WIN && ev_more)) cnt <= '0;
            else if (timed)                               cnt <= cnt + 1'b1;

            if (st == S_READ && nxt != S_READ) begin
                tog6       <= 1'b0;
                tog2       <= 1'b0;
                is_erase   <= ev_chip || ev_sect;
                poll       <= ev_prog ? !prog_d7 : 1'b0;
                any_unprot <= !sect_prot;
            end else begin
                if (rd_start && st != S_READ && st != S_SUSP) tog6 <= !tog6;
                if (rd_start && st != S_READ && is_erase)     tog2 <= !tog2;
                if (st == S_SE_WIN && ev_more && !sect_prot)  any_unprot <= 1'b1;
            end
        end
    end

    always_comb begin
        stat           = '0;
        show_stat      = st != S_READ;
        stat[BIT_POLL] = (st == S_SUSP) ? 1'b1 : poll;
        stat[BIT_TGL]  = tog6;
        stat[BIT_LIM]  = st == S_FAIL;
        stat[BIT_SET]  = is_erase && st != S_SE_WIN;
        stat[BIT_STGL] = tog2;
    end

    assert_prog_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == S_PROG) |-> $past(ev_prog));

    assert_read_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && st != S_READ && st != S_SUSP && nxt == st) |=> tog6 != $past(tog6));

    assert_prot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PROT_PROG && !timer_hit) |=> st == S_PROT_PROG);

    assert_win_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_SE_WIN |-> cnt < CNT_W'(SE_WIN_CYC));

    assert_prot_erase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PROT_ERASE && !timer_hit) |=> st == S_PROT_ERASE);

    assert_susp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SUSP && nxt == S_SUSP) |=> $stable(tog6));

    assert_fail_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == S_FAIL) |-> $past(limit_hit));

    assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FAIL && !ev_reset) |=> st == S_FAIL);

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_stat_pkg::*;
#(
    parameter int ADDR_W         = 21,
    parameter int PROT_PROG_CYC  = 125_000_000,
    parameter int PROT_ERASE_CYC = 50_000,
    parameter int SE_WIN_CYC     = 6_250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [7:0]        array_data,
    input  logic              sect_prot,
    input  logic              all_prot,
    input  logic              op_done,
    input  logic              limit_hit,
    output logic [7:0]        dout
);
    logic wr_strobe, rd_start;
    logic ev_prog, ev_chip, ev_sect, ev_more, ev_susp, ev_reset;
    logic [7:0] stat;
    logic show_stat;

    fsg_bus_sense u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .wr_strobe (wr_strobe),
        .rd_start  (rd_start)
    );

    fsg_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .addr      (addr),
        .din       (din),
        .ev_prog   (ev_prog),
        .ev_chip   (ev_chip),
        .ev_sect   (ev_sect),
        .ev_more   (ev_more),
        .ev_susp   (ev_susp),
        .ev_reset  (ev_reset)
    );

    fsg_op_ctrl #(
        .PROT_PROG_CYC  (PROT_PROG_CYC),
        .PROT_ERASE_CYC (PROT_ERASE_CYC),
        .SE_WIN_CYC     (SE_WIN_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_prog   (ev_prog),
        .ev_chip   (ev_chip),
        .ev_sect   (ev_sect),
        .ev_more   (ev_more),
        .ev_susp   (ev_susp),
        .ev_reset  (ev_reset),
        .rd_start  (rd_start),
        .prog_d7   (din[7]),
        .sect_prot (sect_prot),
        .all_prot  (all_prot),
        .op_done   (op_done),
        .limit_hit (limit_hit),
        .stat      (stat),
        .show_stat (show_stat)
    );

    assign dout = show_stat ? stat : array_data;

    assert_lim_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (show_stat && dout[BIT_LIM]) |=> dout[BIT_LIM] || ev_reset == $past(ev_reset) || !show_stat);

    assert_idle_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(show_stat) && !show_stat) |-> dout == array_data);

endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
    localparam int AW  = 12;
    localparam int PPC = 40;
    localparam int PEC = 30;
    localparam int SWC = 20;
    localparam logic [7:0] ARR = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic sect_prot = 1'b0, all_prot = 1'b0, op_done = 1'b0, limit_hit = 1'b0;
    logic [7:0] dout;
    logic [7:0] v;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_status_gen #(
        .ADDR_W(AW), .PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC), .SE_WIN_CYC(SWC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .array_data(ARR), .sect_prot(sect_prot),
        .all_prot(all_prot), .op_done(op_done), .limit_hit(limit_hit), .dout(dout)
    );

    // program vectors: {protected, data}
    localparam logic [8:0] PG_VEC [4] = '{9'h080, 9'h013, 9'h1F7, 9'h12A};

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic rd(output logic [7:0] r);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); r = dout; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic pulse_lim();
        @(negedge clk); limit_hit = 1'b1;
        @(negedge clk); limit_hit = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd_prog(input logic [7:0] d);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h123, d);
    endtask

    task automatic erase_pre();
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R1 reset dout", dout, ARR);
        rd(v); chk("R1 read in read mode", v, ARR);

        // table-driven program operations
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d;
            logic pr;
            d  = PG_VEC[i][7:0];
            pr = PG_VEC[i][8];
            sect_prot = pr;
            cmd_prog(d);
            sect_prot = 1'b0;
            rd(v); chk("R2 first status read", v, {~d[7], 1'b1, 6'b0});
            rd(v); chk("R3 R10 second status read", v, {~d[7], 7'b0});
            pulse_done();
            if (pr) begin
                rd(v); chk("R5 protected ignores op_done", v, {~d[7], 1'b1, 6'b0});
                idle(PPC + 5);
                rd(v); chk("R5 protected program ends", v, ARR);
            end else begin
                rd(v); chk("R4 program done", v, ARR);
            end
        end

        // R12: aborted sequences
        wr(12'h555, 8'hAA); wr(12'h000, 8'hF0);
        wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h100, 8'h00);
        rd(v); chk("R12 reset write aborts sequence", v, ARR);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h12); wr(12'h555, 8'hA0); wr(12'h100, 8'h00);
        rd(v); chk("R12 mismatched write aborts sequence", v, ARR);
        cmd_prog(8'h80);
        rd(v); chk("R12 busy first read", v, 8'h40);
        wr(12'h000, 8'hF0);
        rd(v); chk("R12 reset write ignored while busy", v, 8'h00);
        pulse_done();
        rd(v); chk("R4 done after ignored reset", v, ARR);

        // R11 during program
        cmd_prog(8'h00);
        rd(v); chk("R11 program status", v, 8'hC0);
        pulse_lim();
        rd(v); chk("R11 limit bit set", v, 8'hA0);
        pulse_done();
        rd(v); chk("R11 op_done ignored, toggle continues", v, 8'hE0);
        wr(12'h000, 8'hF0);
        rd(v); chk("R11 reset write recovers", v, ARR);

        // R7 R9 R10 R11 sector erase sequence
        erase_pre(); wr(12'h800, 8'h30);
        rd(v); chk("R7 window open", v, 8'h44);
        idle(12);
        wr(12'h900, 8'h30);
        idle(12);
        rd(v); chk("R7 window restarted", v, 8'h00);
        idle(SWC + 5);
        rd(v); chk("R7 window closed erase running", v, 8'h4C);
        wr(12'h000, 8'hB0);
        rd(v); chk("R9 suspended read 1", v, 8'hC8);
        rd(v); chk("R9 R10 suspended read 2", v, 8'hCC);
        wr(12'h000, 8'h30);
        rd(v); chk("R9 resumed", v, 8'h08);
        pulse_lim();
        rd(v); chk("R11 erase limit", v, 8'h6C);
        pulse_done();
        rd(v); chk("R11 erase fail holds", v, 8'h28);
        wr(12'h000, 8'hF0);
        rd(v); chk("R11 erase fail reset", v, ARR);

        // R6 R4 normal chip erase
        erase_pre(); wr(12'h555, 8'h10);
        rd(v); chk("R6 chip erase status", v, 8'h4C);
        pulse_done();
        rd(v); chk("R4 chip erase done", v, ARR);

        // R8 all-protected chip erase
        all_prot = 1'b1;
        erase_pre(); wr(12'h555, 8'h10);
        all_prot = 1'b0;
        rd(v); chk("R8 protected chip erase", v, 8'h4C);
        pulse_done();
        rd(v); chk("R8 ignores op_done", v, 8'h08);
        idle(PEC + 5);
        rd(v); chk("R8 protected chip erase ends", v, ARR);

        // R8 sector erase with only protected sectors
        sect_prot = 1'b1;
        erase_pre(); wr(12'h800, 8'h30);
        sect_prot = 1'b0;
        idle(SWC + 5);
        rd(v); chk("R8 protected sector erase after window", v, 8'h4C);
        idle(PEC + 5);
        rd(v); chk("R8 protected sector erase ends", v, ARR);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule